// File: doc/BRIEF.md
# Multifunction ALU with Barrel Shifter

This block is the purely combinational arithmetic/logic unit of a small load/store processor. It takes two data operands, a constant shift-amount field from the instruction and eight control signals, and produces one data result in the same cycle. The control signals form four fields: a two-bit function class, a one-bit add/subtract select, a three-bit shifter control and a two-bit logic-function select.

Inside, three units work in parallel on the same operands: an adder/subtractor (which also supplies the signed less-than decision), a bitwise logic unit and a staged barrel shifter. The shifter moves operand B by an amount taken either from the constant field or from the low bits of operand A, with logical left, logical right or arithmetic right behaviour. A final multiplexer selects one unit's output according to the function class. There is no overflow trap, multiply or divide.

Top module: `sc_alu`

## Requirements
- R1: The function class `fn_class` selects the result source: 2'b00 shifter, 2'b01 set-less-than, 2'b10 adder/subtractor, 2'b11 logic unit.
- R2: In the arithmetic class, `sub_sel`=0 gives `op_a + op_b` and `sub_sel`=1 gives `op_a - op_b`, both modulo 2^WIDTH with no trap on overflow.
- R3: In the logic class, `logic_sel` 2'b00 gives AND, 2'b01 OR, 2'b10 XOR and 2'b11 NOR of the two operands.
- R4: In the set-less-than class the result is 1 when `op_a` is below `op_b` as two's-complement numbers (correct also when the difference overflows, e.g. the most-negative value) and 0 otherwise; all upper bits are 0 and `sub_sel` has no effect.
- R5: `shift_ctl[2]`=0 takes the shift amount from the `shamt` port; `shift_ctl[2]`=1 takes it from `op_a[4:0]` (low log2(WIDTH) bits) and ignores the upper bits of `op_a`.
- R6: `shift_ctl[1:0]` picks the shift kind: 2'b00 and 2'b01 logical left with zero fill, 2'b10 logical right with zero fill, 2'b11 arithmetic right filling with copies of `op_b`'s sign bit.
- R7: The shifted operand is `op_b`; an amount of 0 returns `op_b` unchanged and an amount of WIDTH-1 leaves a single original bit or a full word of fill.
- R8: Control fields belonging to units not selected by `fn_class` have no effect on the result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_a | input | WIDTH (32) | First operand; low bits are the variable shift amount |
| op_b | input | WIDTH (32) | Second operand; the value that the shifter moves |
| shamt | input | log2(WIDTH) (5) | Constant shift amount from the instruction |
| fn_class | input | 2 | Function class select |
| sub_sel | input | 1 | 0 add, 1 subtract |
| shift_ctl | input | 3 | Bit 2 amount source, bits 1:0 shift kind |
| logic_sel | input | 2 | Logic function select |
| result | output | WIDTH (32) | Selected unit output |

## Verification
The hardest outcomes to reach are the set-less-than cases where the subtraction overflows, since the sign of the difference then points the wrong way; they only appear when one operand is near the most-negative value and the other has opposite sign. The bench crosses all 256 control words with an operand set built around 0x80000000, 0x7FFFFFFF, -1, 0 and 1, so every overflowing pair is met in every class. Arithmetic right shifts of negative values are then walked through all 32 amounts from both amount sources, with upper bits of operand A set to prove they are ignored.

// File: rtl/sc_alu_pkg.sv
`timescale 1ns/1ps
package sc_alu_pkg;

   // Function class: chooses which unit drives the result
   typedef enum logic [1:0] {
      CLS_SHIFT = 2'b00,
      CLS_SLT   = 2'b01,
      CLS_ARITH = 2'b10,
      CLS_LOGIC = 2'b11
   } alu_class_e;

   // Logic-unit function
   typedef enum logic [1:0] {
      LG_AND = 2'b00,
      LG_OR  = 2'b01,
      LG_XOR = 2'b10,
      LG_NOR = 2'b11
   } logic_op_e;

   // Shift kind (low two bits of the shifter control)
   typedef enum logic [1:0] {
      SH_LEFT0 = 2'b00,
      SH_LEFT1 = 2'b01,
      SH_RLOG  = 2'b10,
      SH_RARI  = 2'b11
   } shift_kind_e;

   // Adder implementation variants
   localparam int ADD_PLAIN  = 0;
   localparam int ADD_PREFIX = 1;

   // Position of the amount-source bit in the shifter control
   localparam int SHC_SRC_BIT = 2;

endpackage

// File: rtl/sc_alu_addsub.sv
`timescale 1ns/1ps
module sc_alu_addsub
   import sc_alu_pkg::*;
#(
   parameter int WIDTH      = 32,
   parameter int ADDER_KIND = ADD_PREFIX
) (
   input  logic [WIDTH-1:0] a,
   input  logic [WIDTH-1:0] b,
   input  logic             sub,
   output logic [WIDTH-1:0] sum,
   output logic             ovf
);

   localparam int LV = $clog2(WIDTH);

   logic [WIDTH-1:0] bx;
   logic             cin;

   // Subtraction: invert the second operand and inject a carry of one
   assign bx  = sub ? ~b : b;
   assign cin = sub;

   generate
      if (ADDER_KIND == ADD_PLAIN) begin : g_plain
         logic [WIDTH:0] wide;
         assign wide = {1'b0, a} + {1'b0, bx} + {{WIDTH{1'b0}}, cin};
         assign sum  = wide[WIDTH-1:0];
         assign ovf  = (a[WIDTH-1] == bx[WIDTH-1]) && (wide[WIDTH-1] != a[WIDTH-1]);
      end else if (ADDER_KIND == ADD_PREFIX) begin : g_prefix
         logic [WIDTH-1:0] gv [0:LV];
         logic [WIDTH-1:0] pv [0:LV];
         logic [WIDTH-1:0] hsum;
         logic [WIDTH-1:0] cout_v;
         logic [WIDTH-1:0] cin_v;

         assign gv[0] = a & bx;
         assign pv[0] = a ^ bx;
         assign hsum  = a ^ bx;

         // Log-depth prefix network: each level merges spans D apart
         for (genvar lvl = 0; lvl < LV; lvl++) begin : g_lvl
            localparam int D = 1 << lvl;
            logic [WIDTH-1:0] low_ones;
            assign low_ones    = {WIDTH{1'b1}} >> (WIDTH - D);
            assign gv[lvl+1]   = gv[lvl] | (pv[lvl] & (gv[lvl] << D));
            assign pv[lvl+1]   = pv[lvl] & ((pv[lvl] << D) | low_ones);
         end

         // Carry out of each position, folding in the carry-in
         assign cout_v = gv[LV] | (pv[LV] & {WIDTH{cin}});
         assign cin_v  = {cout_v[WIDTH-2:0], cin};
         assign sum    = hsum ^ cin_v;
         assign ovf    = cout_v[WIDTH-1] ^ cout_v[WIDTH-2];
      end else begin : g_bad
         $error("sc_alu_addsub: unknown ADDER_KIND %0d", ADDER_KIND);
      end
   endgenerate

endmodule

// File: rtl/sc_alu_logic.sv
`timescale 1ns/1ps
module sc_alu_logic
   import sc_alu_pkg::*;
#(
   parameter int WIDTH = 32
) (
   input  logic [WIDTH-1:0] a,
   input  logic [WIDTH-1:0] b,
   input  logic [1:0]       sel,
   output logic [WIDTH-1:0] y
);

   always_comb begin
      unique case (logic_op_e'(sel))
         LG_AND:  y = a & b;
         LG_OR:   y = a | b;
         LG_XOR:  y = a ^ b;
         LG_NOR:  y = ~(a | b);
         default: y = '0;
      endcase
   end

endmodule

// File: rtl/sc_alu_shifter.sv
`timescale 1ns/1ps
module sc_alu_shifter
   import sc_alu_pkg::*;
#(
   parameter int WIDTH = 32,
   localparam int SHW  = $clog2(WIDTH)
) (
   input  logic [WIDTH-1:0] din,
   input  logic [SHW-1:0]   amt,
   input  logic [1:0]       kind,
   output logic [WIDTH-1:0] dout
);

   logic             go_right;
   logic             fill;
   logic [WIDTH-1:0] stg [0:SHW];

   assign go_right = kind[1];
   // Arithmetic right: vacated high positions copy the sign bit
   assign fill     = (shift_kind_e'(kind) == SH_RARI) && din[WIDTH-1];
   assign stg[0]   = din;

   // One stage per amount bit; stage s moves by 2**s positions
   generate
      for (genvar s = 0; s < SHW; s++) begin : g_stage
         localparam int D = 1 << s;
         logic [WIDTH-1:0] hi_mask;
         logic [WIDTH-1:0] lft;
         logic [WIDTH-1:0] rgt;
         assign hi_mask  = ~({WIDTH{1'b1}} >> D);
         assign lft      = stg[s] << D;
         assign rgt      = (stg[s] >> D) | (fill ? hi_mask : '0);
         assign stg[s+1] = amt[s] ? (go_right ? rgt : lft) : stg[s];
      end
   endgenerate

   assign dout = stg[SHW];

endmodule

// File: rtl/sc_alu.sv
`timescale 1ns/1ps
module sc_alu
   import sc_alu_pkg::*;
#(
   parameter int WIDTH      = 32,
   parameter int ADDER_KIND = ADD_PREFIX,
   localparam int SHW       = $clog2(WIDTH)
) (
   input  logic [WIDTH-1:0] op_a,
   input  logic [WIDTH-1:0] op_b,
   input  logic [SHW-1:0]   shamt,
   input  logic [1:0]       fn_class,
   input  logic             sub_sel,
   input  logic [2:0]       shift_ctl,
   input  logic [1:0]       logic_sel,
   output logic [WIDTH-1:0] result
);

   // Elaboration-time parameter checks
   generate
      if (WIDTH < 4 || (WIDTH & (WIDTH - 1)) != 0) begin : g_bad_width
         $error("sc_alu: WIDTH must be a power of two and at least 4");
      end
      if (ADDER_KIND != ADD_PLAIN && ADDER_KIND != ADD_PREFIX) begin : g_bad_kind
         $error("sc_alu: ADDER_KIND out of range");
      end
   endgenerate

   logic [WIDTH-1:0] sum_w;
   logic             ovf_w;
   logic             do_sub;
   logic [WIDTH-1:0] logic_w;
   logic [WIDTH-1:0] shift_w;
   logic [SHW-1:0]   amt_w;
   logic [WIDTH-1:0] slt_w;

   // Set-less-than always subtracts, whatever the add/subtract bit says
   assign do_sub = sub_sel || (alu_class_e'(fn_class) == CLS_SLT);

   sc_alu_addsub #(
      .WIDTH      (WIDTH),
      .ADDER_KIND (ADDER_KIND)
   ) u_addsub (
      .a   (op_a),
      .b   (op_b),
      .sub (do_sub),
      .sum (sum_w),
      .ovf (ovf_w)
   );

   sc_alu_logic #(
      .WIDTH (WIDTH)
   ) u_logic (
      .a   (op_a),
      .b   (op_b),
      .sel (logic_sel),
      .y   (logic_w)
   );

   // Amount source: instruction field or low bits of operand A
   assign amt_w = shift_ctl[SHC_SRC_BIT] ? op_a[SHW-1:0] : shamt;

   sc_alu_shifter #(
      .WIDTH (WIDTH)
   ) u_shift (
      .din  (op_b),
      .amt  (amt_w),
      .kind (shift_ctl[1:0]),
      .dout (shift_w)
   );

   // Sign of the true difference: sum sign corrected by overflow
   assign slt_w = {{(WIDTH-1){1'b0}}, sum_w[WIDTH-1] ^ ovf_w};

   always_comb begin
      unique case (alu_class_e'(fn_class))
         CLS_SHIFT: result = shift_w;
         CLS_SLT:   result = slt_w;
         CLS_ARITH: result = sum_w;
         CLS_LOGIC: result = logic_w;
         default:   result = '0;
      endcase
   end

endmodule

// File: rtl/sc_alu_chk.sv
`timescale 1ns/1ps
module sc_alu_chk
   import sc_alu_pkg::*;
#(
   parameter int WIDTH  = 32,
   localparam int SHW   = $clog2(WIDTH)
) (
   input logic [WIDTH-1:0] op_a,
   input logic [WIDTH-1:0] op_b,
   input logic [SHW-1:0]   shamt,
   input logic [1:0]       fn_class,
   input logic             sub_sel,
   input logic [2:0]       shift_ctl,
   input logic [1:0]       logic_sel,
   input logic [WIDTH-1:0] result
);

   logic [SHW-1:0] amt_c;
   assign amt_c = shift_ctl[SHC_SRC_BIT] ? op_a[SHW-1:0] : shamt;

   always_comb begin
      if (!$isunknown({op_a, op_b, shamt, fn_class, sub_sel, shift_ctl, logic_sel})) begin
         // R2
         add_sub_chk: assert (fn_class != 2'b10 ||
                              result == (sub_sel ? op_a - op_b : op_a + op_b))
            else $error("add_sub_chk");
         // R4
         slt_upper_zero_chk: assert (fn_class != 2'b01 || result[WIDTH-1:1] == '0)
            else $error("slt_upper_zero_chk");
         // R4
         slt_signed_chk: assert (fn_class != 2'b01 ||
                                 result[0] == ($signed(op_a) < $signed(op_b)))
            else $error("slt_signed_chk");
         // R3
         nor_chk: assert (fn_class != 2'b11 || logic_sel != 2'b11 ||
                          result == ~(op_a | op_b))
            else $error("nor_chk");
         // R7
         zero_shift_chk: assert (fn_class != 2'b00 || amt_c != '0 || result == op_b)
            else $error("zero_shift_chk");
         // R6
         sra_sign_chk: assert (fn_class != 2'b00 || shift_ctl[1:0] != 2'b11 ||
                               result[WIDTH-1] == op_b[WIDTH-1])
            else $error("sra_sign_chk");
         // R6
         srl_zero_fill_chk: assert (fn_class != 2'b00 || shift_ctl[1:0] != 2'b10 ||
                                    amt_c == '0 || result[WIDTH-1] == 1'b0)
            else $error("srl_zero_fill_chk");
      end
   end

endmodule

bind sc_alu sc_alu_chk #(.WIDTH(WIDTH)) u_sc_alu_chk (.*);

// File: tb/sc_alu_bench.sv
`timescale 1ns/1ps
module sc_alu_bench;

   localparam int W = 32;

   logic          clk = 1'b0;
   logic [W-1:0]  op_a, op_b, result;
   logic [4:0]    shamt;
   logic [1:0]    fn_class, logic_sel;
   logic          sub_sel;
   logic [2:0]    shift_ctl;

   int n_chk  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   always #4 clk = ~clk;

   sc_alu u_sc_alu (
      .op_a      (op_a),
      .op_b      (op_b),
      .shamt     (shamt),
      .fn_class  (fn_class),
      .sub_sel   (sub_sel),
      .shift_ctl (shift_ctl),
      .logic_sel (logic_sel),
      .result    (result)
   );

   // Behavioural model written from the requirements
   function automatic logic [W-1:0] model(input logic [W-1:0] a, input logic [W-1:0] b,
                                          input logic [4:0] sh, input logic [7:0] ctl);
      logic [4:0] amt;
      amt = ctl[4] ? a[4:0] : sh;                        // R5
      case (ctl[7:6])
         2'b00: begin                                    // R6, R7
            if (ctl[3:2] == 2'b11)      model = W'($signed(b) >>> amt);
            else if (ctl[3:2] == 2'b10) model = b >> amt;
            else                        model = b << amt;
         end
         2'b01:   model = ($signed(a) < $signed(b)) ? 32'd1 : 32'd0; // R4
         2'b10:   model = ctl[5] ? a - b : a + b;        // R2
         default: case (ctl[1:0])                        // R3
                     2'b00:   model = a & b;
                     2'b01:   model = a | b;
                     2'b10:   model = a ^ b;
                     default: model = ~(a | b);
                  endcase
      endcase
   endfunction

   function automatic string tag_of(input logic [7:0] ctl);
      case (ctl[7:6])
         2'b00:   tag_of = ctl[4] ? "R1 R5 R6 R7 R8" : "R1 R6 R7 R8";
         2'b01:   tag_of = "R1 R4 R8";
         2'b10:   tag_of = "R1 R2 R8";
         default: tag_of = "R1 R3 R8";
      endcase
   endfunction

   task automatic run(input logic [W-1:0] a, input logic [W-1:0] b,
                      input logic [4:0] sh, input logic [7:0] ctl, input string tag);
      logic [W-1:0] exp_v;
      @(negedge clk);
      op_a      = a;
      op_b      = b;
      shamt     = sh;
      fn_class  = ctl[7:6];
      sub_sel   = ctl[5];
      shift_ctl = ctl[4:2];
      logic_sel = ctl[1:0];
      #2;
      exp_v = model(a, b, sh, ctl);
      n_chk++;
      if (result !== exp_v) begin
         n_fail++;
         $display("FAIL %s: a=%h b=%h sh=%0d ctl=%b got %h expected %h",
                  tag, a, b, sh, ctl, result, exp_v);
      end
   endtask

   function automatic logic [W-1:0] val(input int i);
      case (i)
         0: val = 32'h0000_0000;
         1: val = 32'h0000_0001;
         2: val = 32'hFFFF_FFFF;
         3: val = 32'h8000_0000;
         4: val = 32'h7FFF_FFFF;
         5: val = 32'h1234_5678;
         6: val = 32'hDEAD_BEEF;
         default: val = 32'h5555_AAAA;
      endcase
   endfunction

   function automatic logic [4:0] amt_of(input int i);
      case (i)
         0: amt_of = 5'd0;
         1: amt_of = 5'd1;
         2: amt_of = 5'd17;
         default: amt_of = 5'd31;
      endcase
   endfunction

   initial begin
      // Idle state: all-zero inputs give a zero result (shift class, amount 0)
      run('0, '0, 5'd0, 8'h00, "R1 R7 idle");

      // Full control-word sweep over edge-value operands and amounts
      for (int c = 0; c < 256; c++)
         for (int ia = 0; ia < 8; ia++)
            for (int ib = 0; ib < 8; ib++)
               for (int is = 0; is < 4; is++)
                  run(val(ia), val(ib), amt_of(is), 8'(c), tag_of(8'(c)));

      // R6 arithmetic right shift of negatives, every amount, both sources
      for (int k = 0; k < 32; k++) begin
         run(32'h0, 32'h8000_0000, 5'(k), 8'b00_0_0_11_00, "R6 sra const");
         run({27'h5A5A5A5, 5'(k)}, 32'hC000_0001, 5'd0, 8'b00_0_1_11_00, "R5 R6 sra var");
         run({27'h7FFFFFF, 5'(k)}, 32'hF0F0_F0F0, 5'd3, 8'b00_0_1_10_00, "R5 R6 srl var");
         run(32'h0, 32'h0000_0001, 5'(k), 8'b00_0_0_01_00, "R6 sll alt code");
      end

      // R4 most-negative value and overflow pairs
      run(32'h8000_0000, 32'h0000_0001, 5'd0, 8'b01_0_000_00, "R4 minneg<1");
      run(32'h0000_0001, 32'h8000_0000, 5'd0, 8'b01_1_000_11, "R4 1<minneg");
      run(32'h8000_0000, 32'h8000_0000, 5'd0, 8'b01_0_000_00, "R4 equal");
      run(32'h7FFF_FFFF, 32'h8000_0000, 5'd0, 8'b01_1_000_00, "R4 maxpos");
      run(32'h8000_0000, 32'h7FFF_FFFF, 5'd0, 8'b01_0_000_00, "R4 minneg<maxpos");

      // R7 amount 31 extremes
      run(32'h0, 32'h8000_0000, 5'd31, 8'b00_0_0_10_00, "R7 srl 31");
      run(32'h0, 32'h0000_0001, 5'd31, 8'b00_0_0_00_00, "R7 sll 31");

      // R8 random operands with varying unused fields
      for (int r = 0; r < 2000; r++)
         run($urandom, $urandom, 5'($urandom), 8'($urandom), "R8 random");

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      #(8 * 190000);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

endmodule